// File: doc/BRIEF.md
# Permuting Multi-Lane MAC Datapath

This block is a fixed-point vector multiply-accumulate engine with eight output lanes. In one operation each lane forms up to four column products and adds their sum into its own 48-bit accumulator. The operands come from three wide sources. The X buffer holds 64 signed 16-bit elements. The optional Y buffer has the same shape and is added element-wise to X before the multiply. The coefficient Z buffer holds 16 signed 16-bit elements. Two lanes may pick the same Z element, so one coefficient can feed several multipliers.

Each lane finds its operands through a start index, a per-lane 4-bit offset and the column number. The offsets for all eight lanes are packed into one 32-bit word. The X and Y elements are chosen by the same X index. Z has its own start and offset word. A control bit decides whether the new column sum is added to the held lane value or replaces it. The result and a valid flag are registered, so they appear one clock after the operation is presented.

Top module: `permac_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, every accumulator lane and `out_valid` become 0 on that edge.
- R2: `out_valid` is high in exactly those cycles that follow a rising edge at which `in_valid` was high. The lane results of that operation are visible in the same cycle as `out_valid`.
- R3: With `acc_en`=0, an operation loads each lane with its column sum: sum over c of z(lane,c)*a(lane,c), where a is the multiplier operand defined in R7.
- R4: With `acc_en`=1, an operation adds the column sum to the value the lane already holds.
- R5: For lane L and column c, the X (and Y) element index is (`x_start` + nibble L of `x_offs` + c) mod 64. Nibble L is bits [4L+3:4L], so 0x76543210 maps lane L to offset L. Element k of a buffer is bits [16k+15:16k].
- R6: For lane L and column c, the Z element index is (`z_start` + nibble L of `z_offs` + c) mod 16.
- R7: With `pre_en`=1, the multiplier operand is the 17-bit signed sum x+y, without saturation. With `pre_en`=0 the operand is x alone, and `y_buf` has no effect on any lane.
- R8: Only columns 0 through `col_last` contribute, where `col_last` is 0 to 3. The other columns add nothing.
- R9: All elements are signed two's complement. Products are sign-extended to 48 bits, and accumulation wraps modulo 2^48.
- R10: In a cycle without `in_valid`, every accumulator lane keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| acc_en | input | 1 | 1: add to lane value, 0: overwrite lane value |
| pre_en | input | 1 | 1: multiply (x+y), 0: multiply x |
| col_last | input | 2 | Index of the last active column |
| x_buf | input | 1024 | 64 signed 16-bit X elements |
| y_buf | input | 1024 | 64 signed 16-bit Y elements |
| z_buf | input | 256 | 16 signed 16-bit Z coefficients |
| x_start | input | 6 | X/Y start index |
| x_offs | input | 32 | Packed per-lane X/Y offsets, 4 bits each |
| z_start | input | 4 | Z start index |
| z_offs | input | 32 | Packed per-lane Z offsets, 4 bits each |
| out_valid | output | 1 | Registered result valid |
| acc_out | output | 384 | Eight 48-bit signed accumulator lanes, lane L at [48L+47:48L] |

## Verification
The 48-bit wraparound is the hardest state to reach from the ports. Each operation adds at most about 2^33 to a lane, so the bench sets every element to the most negative value, with pre-add and all columns on. It then accumulates for tens of thousands of back-to-back cycles until the positive limit is crossed. The index wraparounds in X and Z are reached with start values near the top of each buffer combined with large offsets. The permutations use offset words other than the identity, so that a swapped nibble or a wrong modulus shows up in a specific lane.

// File: rtl/permac_pkg.sv
package permac_pkg;

  localparam int unsigned ELEM_W = 16;
  localparam int unsigned ACC_W  = 48;
  localparam int unsigned OFF_W  = 4;

  typedef enum logic {
    ACC_LOAD = 1'b0,
    ACC_ADD  = 1'b1
  } acc_mode_e;

  // circular element index: base + lane offset + column, folded into the buffer
  function automatic int unsigned wrap_index(input int unsigned base,
                                             input int unsigned off,
                                             input int unsigned col,
                                             input int unsigned nelem);
    return (base + off + col) % nelem;
  endfunction

endpackage

// File: rtl/permac_opsel.sv
module permac_opsel #(
  parameter int unsigned DW    = 16,
  parameter int unsigned NELEM = 64,
  parameter int unsigned SELW  = 6,
  parameter int unsigned COLS  = 4,
  parameter int unsigned OFFW  = 4
) (
  input  logic [NELEM*DW-1:0] src,
  input  logic [SELW-1:0]     base,
  input  logic [OFFW-1:0]     off,
  output logic [COLS*DW-1:0]  ops
);
  import permac_pkg::*;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [SELW-1:0] idx;
    always_comb begin
      idx = SELW'(wrap_index(int'(base), int'(off), c, NELEM));
    end
    assign ops[c*DW +: DW] = src[idx*DW +: DW];
  end

endmodule

// File: rtl/permac_lane.sv
module permac_lane #(
  parameter int unsigned DW   = 16,
  parameter int unsigned ACCW = 48,
  parameter int unsigned COLS = 4,
  parameter int unsigned CW   = 2
) (
  input  logic [COLS*DW-1:0]   x_ops,
  input  logic [COLS*DW-1:0]   y_ops,
  input  logic [COLS*DW-1:0]   z_ops,
  input  logic                 pre_en,
  input  logic [CW-1:0]        col_last,
  output logic signed [ACCW-1:0] lane_sum
);

  logic signed [ACCW-1:0] prod [COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_mul
    logic signed [DW-1:0] xv, yv, zv;
    logic signed [DW:0]   opnd;
    logic                 active;
    assign xv = x_ops[c*DW +: DW];
    assign yv = y_ops[c*DW +: DW];
    assign zv = z_ops[c*DW +: DW];
    assign active = (int'(col_last) >= c);
    always_comb begin
      if (pre_en) opnd = (DW+1)'(xv) + (DW+1)'(yv);
      else        opnd = (DW+1)'(xv);
    end
    assign prod[c] = active ? (ACCW'(opnd) * ACCW'(zv)) : '0;
  end

  always_comb begin
    lane_sum = '0;
    for (int c = 0; c < COLS; c++) lane_sum = lane_sum + prod[c];
  end

endmodule

// File: rtl/permac_datapath.sv
module permac_datapath #(
  parameter int unsigned LANES = 8,
  parameter int unsigned COLS  = 4,
  parameter int unsigned DW    = permac_pkg::ELEM_W,
  parameter int unsigned ACCW  = permac_pkg::ACC_W,
  parameter int unsigned OFFW  = permac_pkg::OFF_W,
  parameter int unsigned XW    = 1024,
  parameter int unsigned ZW    = 256,
  localparam int unsigned XN    = XW / DW,
  localparam int unsigned ZN    = ZW / DW,
  localparam int unsigned XSELW = $clog2(XN),
  localparam int unsigned ZSELW = $clog2(ZN),
  localparam int unsigned CW    = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  acc_en,
  input  logic                  pre_en,
  input  logic [CW-1:0]         col_last,
  input  logic [XW-1:0]         x_buf,
  input  logic [XW-1:0]         y_buf,
  input  logic [ZW-1:0]         z_buf,
  input  logic [XSELW-1:0]      x_start,
  input  logic [LANES*OFFW-1:0] x_offs,
  input  logic [ZSELW-1:0]      z_start,
  input  logic [LANES*OFFW-1:0] z_offs,
  output logic                  out_valid,
  output logic [LANES*ACCW-1:0] acc_out
);
  import permac_pkg::*;

  logic signed [ACCW-1:0] lane_sum [LANES];
  logic signed [ACCW-1:0] acc_q    [LANES];
  acc_mode_e              mode;

  assign mode = acc_mode_e'(acc_en);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [COLS*DW-1:0] x_ops, y_ops, z_ops;

    permac_opsel #(.DW(DW), .NELEM(XN), .SELW(XSELW), .COLS(COLS), .OFFW(OFFW)) u_xsel (
      .src(x_buf), .base(x_start), .off(x_offs[l*OFFW +: OFFW]), .ops(x_ops)
    );
    permac_opsel #(.DW(DW), .NELEM(XN), .SELW(XSELW), .COLS(COLS), .OFFW(OFFW)) u_ysel (
      .src(y_buf), .base(x_start), .off(x_offs[l*OFFW +: OFFW]), .ops(y_ops)
    );
    permac_opsel #(.DW(DW), .NELEM(ZN), .SELW(ZSELW), .COLS(COLS), .OFFW(OFFW)) u_zsel (
      .src(z_buf), .base(z_start), .off(z_offs[l*OFFW +: OFFW]), .ops(z_ops)
    );

    permac_lane #(.DW(DW), .ACCW(ACCW), .COLS(COLS), .CW(CW)) u_lane (
      .x_ops(x_ops), .y_ops(y_ops), .z_ops(z_ops),
      .pre_en(pre_en), .col_last(col_last), .lane_sum(lane_sum[l])
    );

    always_ff @(posedge clk) begin
      if (rst)           acc_q[l] <= '0;
      else if (in_valid) acc_q[l] <= ((mode == ACC_ADD) ? acc_q[l] : '0) + lane_sum[l];
    end

    assign acc_out[l*ACCW +: ACCW] = acc_q[l];

    // R3
    ovw_load_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !acc_en) |=> (acc_q[l] == $past(lane_sum[l])));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(acc_q[l]));
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && (acc_out == '0)));

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  valid_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

endmodule

// File: tb/permac_datapath_tb.sv
`timescale 1ns/1ps
module permac_datapath_tb;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          acc_en = 1'b0;
  logic          pre_en = 1'b0;
  logic [1:0]    col_last = 2'd3;
  logic [1023:0] x_buf = '0;
  logic [1023:0] y_buf = '0;
  logic [255:0]  z_buf = '0;
  logic [5:0]    x_start = '0;
  logic [31:0]   x_offs = 32'h76543210;
  logic [3:0]    z_start = '0;
  logic [31:0]   z_offs = 32'h76543210;
  logic          out_valid;
  logic [383:0]  acc_out;

  int     n_checks = 0;
  int     n_fails  = 0;
  int     cycles   = 0;
  bit     started  = 0;
  bit     finished = 0;
  string  tag      = "R1";
  longint model [8];
  bit     exp_valid = 0;

  always #2.5 clk = ~clk;

  permac_datapath u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .acc_en(acc_en), .pre_en(pre_en),
    .col_last(col_last), .x_buf(x_buf), .y_buf(y_buf), .z_buf(z_buf),
    .x_start(x_start), .x_offs(x_offs), .z_start(z_start), .z_offs(z_offs),
    .out_valid(out_valid), .acc_out(acc_out)
  );

  function automatic longint wrap48(input longint v);
    logic signed [47:0] t;
    t = v[47:0];
    return longint'(t);
  endfunction

  function automatic longint elem(input logic [1023:0] b, input int k);
    logic signed [15:0] e;
    e = b[k*16 +: 16];
    return longint'(e);
  endfunction

  // R3 R5 R6 R7 R8: behavioural column sum of one lane
  function automatic longint lane_ref(input int l);
    longint s = 0;
    for (int c = 0; c <= int'(col_last); c++) begin
      int xi = (int'(x_start) + int'(x_offs[4*l +: 4]) + c) % 64;
      int zi = (int'(z_start) + int'(z_offs[4*l +: 4]) + c) % 16;
      longint a = elem(x_buf, xi) + (pre_en ? elem(y_buf, xi) : 0);
      longint z = elem({768'b0, z_buf}, zi);
      s += a * z;
    end
    return s;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      exp_valid = 0;
      for (int l = 0; l < 8; l++) model[l] = 0;
    end else begin
      exp_valid = in_valid;
      if (in_valid)
        for (int l = 0; l < 8; l++)
          model[l] = wrap48((acc_en ? model[l] : 0) + lane_ref(l));
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      n_checks++;
      if (out_valid !== exp_valid) begin
        n_fails++;
        $display("FAIL %s out_valid actual=%0b expected=%0b", tag, out_valid, exp_valid);
      end
      for (int l = 0; l < 8; l++) begin
        logic signed [47:0] got;
        got = acc_out[l*48 +: 48];
        if (longint'(got) !== model[l]) begin
          n_fails++;
          $display("FAIL %s lane %0d actual=%0d expected=%0d", tag, l, longint'(got), model[l]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      finished = 1;
      n_fails++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  task automatic fill_random();
    for (int k = 0; k < 32; k++) begin
      x_buf[k*32 +: 32] = $urandom;
      y_buf[k*32 +: 32] = $urandom;
    end
    for (int k = 0; k < 8; k++) z_buf[k*32 +: 32] = $urandom;
  endtask

  task automatic fill_index();
    for (int k = 0; k < 64; k++) begin
      x_buf[k*16 +: 16] = 16'(k + 1);
      y_buf[k*16 +: 16] = 16'(1000 * (k + 1));
    end
    for (int k = 0; k < 16; k++) z_buf[k*16 +: 16] = 16'(k * 7 + 3);
  endtask

  task automatic op(input bit acc, input bit pre, input logic [1:0] cl);
    @(negedge clk);
    in_valid = 1; acc_en = acc; pre_en = pre; col_last = cl;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
      x_buf = ~x_buf; y_buf = ~y_buf; acc_en = ~acc_en;
    end
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    idle(1);

    // R3 R5 R6: identity offsets, overwrite, no pre-add
    tag = "R3/R5/R6 identity";
    fill_index();
    x_offs = 32'h76543210; z_offs = 32'h76543210;
    op(0, 0, 2'd3);
    x_start = 6'd10; z_start = 4'd2;
    op(0, 0, 2'd3);

    // R5 R6: permuted offsets and wraparound in both buffers
    tag = "R5/R6 wrap";
    x_offs = 32'hF0E1A5C3; z_offs = 32'h2F9E0D7B;
    x_start = 6'd62; z_start = 4'd15;
    op(0, 0, 2'd3);
    x_start = 6'd55; z_start = 4'd9;
    op(0, 0, 2'd3);

    // R7: pre-add on, then off with a different Y
    tag = "R7 preadd";
    op(0, 1, 2'd3);
    for (int k = 0; k < 64; k++) y_buf[k*16 +: 16] = 16'h7FFF;
    op(0, 0, 2'd3);
    op(0, 1, 2'd3);

    // R8: every column count
    tag = "R8 cols";
    for (int c = 0; c < 4; c++) op(0, 1, 2'(c));

    // R2 R4 R10: accumulate runs with idle gaps
    tag = "R2/R4/R10 acc";
    fill_random();
    op(0, 1, 2'd3);
    op(1, 1, 2'd2);
    idle(3);
    op(1, 0, 2'd1);
    op(1, 1, 2'd3);
    idle(2);

    // R1: reset in the middle of a run
    tag = "R1 midreset";
    @(negedge clk); rst = 1; in_valid = 1;
    @(negedge clk); rst = 0; in_valid = 0;
    idle(1);

    // R9: signed extremes and 48-bit wraparound
    tag = "R9 wrap";
    for (int k = 0; k < 64; k++) begin
      x_buf[k*16 +: 16] = 16'h8000; y_buf[k*16 +: 16] = 16'h8000;
    end
    for (int k = 0; k < 16; k++) z_buf[k*16 +: 16] = 16'h8000;
    op(0, 1, 2'd3);
    for (int i = 0; i < 17000; i++) op(1, 1, 2'd3);
    for (int k = 0; k < 16; k++) z_buf[k*16 +: 16] = 16'h7FFF;
    op(0, 0, 2'd3);

    // random mix of all controls
    tag = "R3/R4/R7/R8 random";
    for (int i = 0; i < 1500; i++) begin
      fill_random();
      x_start = 6'($urandom); z_start = 4'($urandom);
      x_offs = $urandom; z_offs = $urandom;
      if ($urandom_range(0, 4) == 0) idle(1);
      else op(1'($urandom), 1'($urandom), 2'($urandom));
    end
    idle(2);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule